// File: doc/BRIEF.md
# Radar Pulse Event History Buffer

This block keeps a short history of radar pulse events for a downstream pattern matcher. Each accepted event is stored with its engine number, its timestamp, its pulse width, and an arrival stamp. The arrival stamp is the value of a free-running tick counter at the moment of the write. Events from one selected engine (engine 2 by default) go to a second circular buffer. Events from every other engine go to the first buffer.

Before a selected-engine event is stored, it is compared with the newest entry of the second buffer. If it arrives too soon after a wide stored pulse, it is dropped. An aging process runs on every clock. It removes the oldest entry of a buffer once that entry's arrival stamp is at least the configured window behind the current tick. When a buffer overflows, its oldest entry is overwritten.

The matcher reads entries through one combinational read port. It picks a buffer and an index, where index 0 is the newest entry. The buffer depth must be a power of two.

Top module: `radar_evt_hist`

## Requirements
- R1: An event with `evt_engine_i` equal to 2 is routed to buffer 1 (`rd_buf_i` = 1). An event from engine 0, 1 or 3 is routed to buffer 0.
- R2: An event accepted at a rising edge can be read at index 0 of its buffer from that edge on. The stored arrival stamp equals `tick_i` at that edge. The buffer's occupancy output increases by one, unless the buffer is full.
- R3: The read port returns entries newest first. Index k returns the entry written k writes before the newest. `rd_valid_o` is 1 exactly when k is less than the occupancy of the selected buffer.
- R4: A buffer holds at most DEPTH-1 entries (15 by default). A write to a full buffer discards its oldest entry, and the occupancy stays at DEPTH-1.
- R5: An engine-2 event is dropped, leaving buffer 1 unchanged, when all of the following hold: buffer 1 is not empty, the event timestamp minus the newest stored timestamp (modulo 2^32) is below MARGIN (2000), and the newest stored width is at least WIDE_TH (200).
- R6: An engine-2 event is stored when any of the following holds: the newest stored width is below 200, the timestamp gap is at least 2000, or buffer 1 is empty. Events routed to buffer 0 are never dropped.
- R7: On each edge without a write to it, a non-empty buffer drops its oldest entry if `tick_i` minus that entry's arrival stamp (modulo 2^32) is at least `age_win_i`. At most one entry is dropped per edge. A fresh oldest entry stops the aging.
- R8: A buffer is not aged on an edge at which it is written.
- R9: The timestamp gap and the arrival age are computed correctly when the 32-bit timestamp or the tick counter wraps through zero.
- R10: Asserting `rst_ni` low empties both buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event offered on this edge |
| evt_engine_i | input | 2 | Source engine of the event |
| evt_ts_i | input | 32 | Event timestamp |
| evt_width_i | input | 12 | Pulse width |
| tick_i | input | 32 | Free-running tick used for arrival stamps and aging |
| age_win_i | input | 32 | Aging window in ticks |
| rd_buf_i | input | 1 | Buffer to read |
| rd_idx_i | input | 4 | Read index, 0 = newest |
| rd_valid_o | output | 1 | The index holds an entry |
| rd_engine_o | output | 2 | Engine of the entry read |
| rd_ts_o | output | 32 | Timestamp of the entry read |
| rd_width_o | output | 12 | Width of the entry read |
| rd_arrival_o | output | 32 | Arrival stamp of the entry read |
| occ0_o | output | 4 | Entries in buffer 0 |
| occ1_o | output | 4 | Entries in buffer 1 |

## Verification
Writes, drops and aging all take effect at the rising edge where the inputs are sampled, with one register stage. The read port is combinational, so a write or a pop can be seen during the low phase that follows that edge.

The bench drives its inputs just after each falling edge and keeps a reference model that it updates on every rising edge. It walks all indices of a buffer within one low phase, before the next rising edge, so the model and the design are compared in the same state. Aging runs on every edge, including the edges spent on checking, and the model follows it on those edges as well.

// File: rtl/radar_hist_pkg.sv
`timescale 1ns/1ps
package radar_hist_pkg;
  localparam int ENG_W = 2;
  localparam int TS_W  = 32;
  localparam int WID_W = 12;

  typedef struct packed {
    logic [ENG_W-1:0] eng;
    logic [TS_W-1:0]  ts;
    logic [WID_W-1:0] width;
    logic [TS_W-1:0]  arr;
  } hist_evt_t;
endpackage

// File: rtl/hist_ring.sv
`timescale 1ns/1ps
module hist_ring
  import radar_hist_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  hist_evt_t       wr_evt_i,
  input  logic [TS_W-1:0] tick_i,
  input  logic [TS_W-1:0] age_win_i,
  input  logic [PW-1:0]   rd_idx_i,
  output logic            rd_valid_o,
  output hist_evt_t       rd_evt_o,
  output hist_evt_t       newest_o,
  output logic            newest_valid_o,
  output logic [PW-1:0]   occ_o
);
  localparam logic [PW-1:0] ONE  = PW'(1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH - 1);

  logic [PW-1:0]   head_q, tail_q, tail_nx, rd_ptr, last_ptr;
  logic [TS_W-1:0] head_age;
  logic            pop;
  hist_evt_t       mem_q [DEPTH];

  assign occ_o    = tail_q - head_q;
  assign tail_nx  = tail_q + ONE;
  assign last_ptr = tail_q - ONE;
  assign rd_ptr   = last_ptr - rd_idx_i;
  assign head_age = tick_i - mem_q[head_q].arr;
  // aging yields to a write on the same buffer
  assign pop      = !wr_i && (occ_o != '0) && (head_age >= age_win_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (wr_i) begin
      tail_q <= tail_nx;
      if (tail_nx == head_q) head_q <= head_q + ONE;
    end else if (pop) begin
      head_q <= head_q + ONE;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[tail_q] <= wr_evt_i;
  end

  assign rd_valid_o     = rd_idx_i < occ_o;
  assign rd_evt_o       = mem_q[rd_ptr];
  assign newest_o       = mem_q[last_ptr];
  assign newest_valid_o = occ_o != '0;

  a_r4_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && occ_o == FULL) |=> occ_o == FULL);
  a_r2_write_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && occ_o != FULL) |=> occ_o == $past(occ_o) + ONE);
  a_r7_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (occ_o == $past(occ_o)) || (occ_o == $past(occ_o) - ONE));
  a_r7_fresh_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && occ_o != '0 && head_age < age_win_i) |=> occ_o == $past(occ_o));
endmodule

// File: rtl/evt_route.sv
`timescale 1ns/1ps
module evt_route
  import radar_hist_pkg::*;
#(
  parameter int SPLIT_ENG = 2,
  parameter int MARGIN    = 2000,
  parameter int WIDE_TH   = 200
) (
  input  logic      valid_i,
  input  hist_evt_t evt_i,
  input  hist_evt_t newest_i,
  input  logic      newest_valid_i,
  output logic [1:0] wr_o,
  output logic      drop_o
);
  logic            split;
  logic [TS_W-1:0] gap;

  assign split  = evt_i.eng == ENG_W'(SPLIT_ENG);
  assign gap    = evt_i.ts - newest_i.ts;
  assign drop_o = valid_i && split && newest_valid_i &&
                  (gap < TS_W'(MARGIN)) && (newest_i.width >= WID_W'(WIDE_TH));
  assign wr_o[0] = valid_i && !split;
  assign wr_o[1] = valid_i && split && !drop_o;
endmodule

// File: rtl/radar_evt_hist.sv
`timescale 1ns/1ps
module radar_evt_hist
  import radar_hist_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int SPLIT_ENG = 2,
  parameter int MARGIN    = 2000,
  parameter int WIDE_TH   = 200,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [ENG_W-1:0] evt_engine_i,
  input  logic [TS_W-1:0]  evt_ts_i,
  input  logic [WID_W-1:0] evt_width_i,
  input  logic [TS_W-1:0]  tick_i,
  input  logic [TS_W-1:0]  age_win_i,
  input  logic             rd_buf_i,
  input  logic [PW-1:0]    rd_idx_i,
  output logic             rd_valid_o,
  output logic [ENG_W-1:0] rd_engine_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic [WID_W-1:0] rd_width_o,
  output logic [TS_W-1:0]  rd_arrival_o,
  output logic [PW-1:0]    occ0_o,
  output logic [PW-1:0]    occ1_o
);
  localparam int NBUF = 2;

  hist_evt_t     in_evt, sel_evt;
  hist_evt_t     rd_evt [NBUF];
  hist_evt_t     newest [NBUF];
  logic          rd_v   [NBUF];
  logic          new_v  [NBUF];
  logic [PW-1:0] occ    [NBUF];
  logic [1:0]    wr;
  logic          drop;

  assign in_evt = '{eng: evt_engine_i, ts: evt_ts_i, width: evt_width_i, arr: tick_i};

  evt_route #(.SPLIT_ENG(SPLIT_ENG), .MARGIN(MARGIN), .WIDE_TH(WIDE_TH)) u_route (
    .valid_i        (evt_valid_i),
    .evt_i          (in_evt),
    .newest_i       (newest[1]),
    .newest_valid_i (new_v[1]),
    .wr_o           (wr),
    .drop_o         (drop)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    hist_ring #(.DEPTH(DEPTH)) u_ring (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (wr[g]),
      .wr_evt_i       (in_evt),
      .tick_i         (tick_i),
      .age_win_i      (age_win_i),
      .rd_idx_i       (rd_idx_i),
      .rd_valid_o     (rd_v[g]),
      .rd_evt_o       (rd_evt[g]),
      .newest_o       (newest[g]),
      .newest_valid_o (new_v[g]),
      .occ_o          (occ[g])
    );
  end

  assign sel_evt      = rd_evt[rd_buf_i];
  assign rd_valid_o   = rd_v[rd_buf_i];
  assign rd_engine_o  = sel_evt.eng;
  assign rd_ts_o      = sel_evt.ts;
  assign rd_width_o   = sel_evt.width;
  assign rd_arrival_o = sel_evt.arr;
  assign occ0_o       = occ[0];
  assign occ1_o       = occ[1];

  a_r5_drop_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> occ1_o <= $past(occ1_o));
  a_r1_split_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_engine_i == ENG_W'(SPLIT_ENG) && !drop) |=> occ1_o != '0);
  a_r1_other_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_engine_i != ENG_W'(SPLIT_ENG)) |=> occ0_o != '0);
  a_r6_first_never_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_engine_i != ENG_W'(SPLIT_ENG)) |-> !drop);
endmodule

// File: tb/tb_radar_evt_hist.sv
`timescale 1ns/1ps
module tb_radar_evt_hist;
  localparam int DEPTH  = 16;
  localparam int PW     = 4;
  localparam int MARGIN = 2000;
  localparam int WIDE   = 200;
  localparam int SPLIT  = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  eng = '0;
  logic [31:0] ts = '0, tick = '0, win = 32'hFFFF_FFFF, jump_val = '0;
  logic [11:0] wid = '0;
  logic        jump = 1'b0;
  logic        rd_buf = 1'b0;
  logic [PW-1:0] rd_idx = '0;
  logic        rd_valid;
  logic [1:0]  rd_eng;
  logic [31:0] rd_ts, rd_arr;
  logic [11:0] rd_wid;
  logic [PW-1:0] occ0, occ1;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  radar_evt_hist #(.DEPTH(DEPTH), .SPLIT_ENG(SPLIT), .MARGIN(MARGIN), .WIDE_TH(WIDE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(valid), .evt_engine_i(eng),
    .evt_ts_i(ts), .evt_width_i(wid), .tick_i(tick), .age_win_i(win),
    .rd_buf_i(rd_buf), .rd_idx_i(rd_idx), .rd_valid_o(rd_valid),
    .rd_engine_o(rd_eng), .rd_ts_o(rd_ts), .rd_width_o(rd_wid),
    .rd_arrival_o(rd_arr), .occ0_o(occ0), .occ1_o(occ1)
  );

  always #2 clk = ~clk;

  always @(negedge clk) tick <= jump ? jump_val : tick + 32'd1;

  typedef struct {
    logic [1:0]  eng;
    logic [31:0] ts;
    logic [11:0] w;
    logic [31:0] arr;
  } m_t;
  m_t mq0[$];
  m_t mq1[$];

  // reference model, updated on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq0.delete();
      mq1.delete();
    end else begin
      m_t e;
      logic w0, w1, rej;
      logic [31:0] d;
      e.eng = eng; e.ts = ts; e.w = wid; e.arr = tick;
      w0 = 0; w1 = 0; rej = 0;
      if (valid) begin
        if (eng == 2'(SPLIT)) begin
          if (mq1.size() > 0) begin
            d = ts - mq1[$].ts;
            if (d < 32'(MARGIN) && mq1[$].w >= 12'(WIDE)) rej = 1;
          end
          w1 = !rej;
        end else w0 = 1;
      end
      if (w0) begin
        mq0.push_back(e);
        if (mq0.size() > DEPTH - 1) void'(mq0.pop_front());
      end else if (mq0.size() > 0) begin
        d = tick - mq0[0].arr;
        if (d >= win) void'(mq0.pop_front());
      end
      if (w1) begin
        mq1.push_back(e);
        if (mq1.size() > DEPTH - 1) void'(mq1.pop_front());
      end else if (mq1.size() > 0) begin
        d = tick - mq1[0].arr;
        if (d >= win) void'(mq1.pop_front());
      end
    end
  end

  task automatic slot();
    @(negedge clk);
    #0.2;
  endtask

  task automatic evt(input logic [1:0] e, input logic [31:0] t, input logic [11:0] w);
    slot();
    valid = 1'b1; eng = e; ts = t; wid = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      slot();
      valid = 1'b0;
    end
  endtask

  task automatic set_tick(input logic [31:0] v);
    slot();
    valid = 1'b0; jump_val = v; jump = 1'b1;
    slot();
    jump = 1'b0;
  endtask

  task automatic do_reset();
    slot();
    valid = 1'b0; rst_n = 1'b0;
    slot();
    rst_n = 1'b1;
  endtask

  // walks every index of one buffer within a single low phase
  task automatic check_buf(input int b, input string tag);
    int sz, bad;
    m_t e;
    logic [PW-1:0] occ_act;
    slot();
    valid = 1'b0;
    bad = 0;
    n_chk++;
    sz = (b == 1) ? mq1.size() : mq0.size();
    for (int k = 0; k < DEPTH; k++) begin
      logic exp_v;
      rd_buf = b[0];
      rd_idx = k[PW-1:0];
      #0.1;
      exp_v = k < sz;
      if (rd_valid !== exp_v) begin
        if (bad == 0) $display("FAIL %s buf%0d idx%0d valid act %0b exp %0b", tag, b, k, rd_valid, exp_v);
        bad++;
      end else if (exp_v) begin
        e = (b == 1) ? mq1[sz-1-k] : mq0[sz-1-k];
        if (rd_eng !== e.eng || rd_ts !== e.ts || rd_wid !== e.w || rd_arr !== e.arr) begin
          if (bad == 0)
            $display("FAIL %s buf%0d idx%0d act eng%0d ts%h w%0d arr%h exp eng%0d ts%h w%0d arr%h",
                     tag, b, k, rd_eng, rd_ts, rd_wid, rd_arr, e.eng, e.ts, e.w, e.arr);
          bad++;
        end
      end
    end
    occ_act = (b == 1) ? occ1 : occ0;
    if (occ_act !== PW'(sz)) begin
      if (bad == 0) $display("FAIL %s buf%0d occupancy act %0d exp %0d", tag, b, occ_act, sz);
      bad++;
    end
    if (bad != 0) n_err++;
  endtask

  task automatic check_both(input string tag);
    check_buf(0, tag);
    check_buf(1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] cur;
    void'($urandom(32'd20240611));
    do_reset();
    check_both("R10 reset empty");

    // R1 routing
    evt(2'd0, 32'd100, 12'd50);
    evt(2'd1, 32'd200, 12'd60);
    evt(2'd3, 32'd300, 12'd70);
    evt(2'd2, 32'd400, 12'd80);
    check_both("R1 routing");

    // R2 / R3 arrival and ordering
    evt(2'd0, 32'd500, 12'd11);
    idle(3);
    evt(2'd1, 32'd600, 12'd12);
    check_buf(0, "R2 arrival stamp");
    check_buf(0, "R3 newest first");

    // R4 overflow
    for (int i = 0; i < 18; i++) evt(2'd1, 32'd1000 + 32'(i), 12'(i + 3));
    check_buf(0, "R4 overflow");
    evt(2'd0, 32'd2000, 12'd9);
    check_buf(0, "R4 full write");

    // R5 / R6 suppression
    evt(2'd2, 32'd10000, 12'd250);
    evt(2'd2, 32'd11999, 12'd90);
    check_buf(1, "R5 drop close after wide");
    evt(2'd2, 32'd12000, 12'd90);
    check_buf(1, "R6 gap equals margin");
    evt(2'd2, 32'd12100, 12'd199);
    evt(2'd2, 32'd12200, 12'd10);
    check_buf(1, "R6 width 199 not wide");
    evt(2'd2, 32'd13000, 12'd200);
    evt(2'd2, 32'd13001, 12'd5);
    check_buf(1, "R5 width 200 is wide");
    evt(2'd0, 32'd13002, 12'd5);
    check_buf(0, "R6 buffer 0 never drops");
    do_reset();
    evt(2'd2, 32'd5, 12'd5);
    check_buf(1, "R6 empty buffer accepts");

    // R7 aging
    do_reset();
    win = 32'd10;
    evt(2'd0, 32'd1, 12'd1);
    evt(2'd0, 32'd2, 12'd2);
    evt(2'd3, 32'd3, 12'd3);
    idle(4);
    evt(2'd1, 32'd4, 12'd4);
    evt(2'd2, 32'd5, 12'd5);
    for (int i = 0; i < 14; i++) check_both("R7 aging");

    // R8 no aging while writing
    do_reset();
    win = 32'd3;
    for (int i = 0; i < 9; i++) evt(2'd0, 32'(50 + i), 12'(i));
    check_buf(0, "R8 no pop on write");
    for (int i = 0; i < 4; i++) check_buf(0, "R8 aging resumes");

    // R9 wraparound
    do_reset();
    win = 32'd20;
    set_tick(32'hFFFF_FFF0);
    evt(2'd2, 32'hFFFF_FF00, 12'd300);
    evt(2'd2, 32'h0000_0100, 12'd1);
    check_buf(1, "R9 gap across wrap");
    evt(2'd2, 32'h0000_0800, 12'd1);
    check_buf(1, "R9 gap across wrap accept");
    for (int i = 0; i < 12; i++) check_buf(1, "R9 age across wrap");

    // R10 reset mid-run
    win = 32'hFFFF_FFFF;
    evt(2'd0, 32'd7, 12'd7);
    evt(2'd2, 32'd8, 12'd7);
    do_reset();
    check_both("R10 reset clears");

    // random mix
    cur = 32'd100;
    for (int r = 0; r < 120; r++) begin
      win = (r % 3 == 0) ? 32'hFFFF_FFFF : 32'($urandom_range(15, 80));
      for (int i = 0; i < 20; i++) begin
        if ($urandom_range(0, 3) != 0) begin
          cur = cur + 32'($urandom_range(1, 2500));
          evt(2'($urandom_range(0, 3)), cur, 12'($urandom_range(0, 400)));
        end else idle(1);
      end
      check_both("R5 R7 random");
      if (r == 60) begin
        do_reset();
        check_both("R10 random reset");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule